// File: doc/BRIEF.md
# Block Transfer Micro-Op Sequencer

This block takes one multi-register load or store instruction and turns it into a stream of simple micro-operations, one per handshake. The instruction arrives as a 16-bit register mask, a base register number and five flag bits: pre-increment, ascending direction, user-bank aliasing, base update and load select. The sequencer first emits a micro-op that copies the base register into a scratch register. It then emits one load or store per set mask bit, each with a byte offset from that scratch register. If base update is requested, it ends with an add or subtract on the base.

The downstream pipeline consumes the stream through a valid/ready pair. A new instruction is taken only while the sequencer is idle. Address arithmetic, memory access and register writes belong to the consumer. This block only orders the operations and annotates them.

Top module: `blkxfer_seq`

## Requirements
- R1: An instruction with N set mask bits yields exactly N+1 micro-ops, or N+2 when base update (`in_wb`) is set. The sequencer then goes idle.
- R2: The first micro-op has kind 0 (copy), register field equal to the scratch index `TEMP_REG` (default 32), base field equal to `in_rn`, and offset 0. It appears on the cycle after the instruction is accepted.
- R3: Transfer micro-ops visit the set mask bits from bit 0 upward. Each carries base field `TEMP_REG` and register field equal to the bit position.
- R4: The first transfer offset is 0 when `in_up` is 1 and 4N-4 when `in_up` is 0. Four more is added when `in_pre` is 1.
- R5: Each following transfer offset is the previous one plus 4 when ascending and minus 4 when descending.
- R6: Transfers have kind 1 (load) when `in_load` is 1 and kind 2 (store) otherwise.
- R7: When `in_user` is 1, every transfer register field is the bit position plus `USER_OFS` (default 40).
- R8: With base update, the final micro-op has register and base fields equal to `in_rn` and offset 4N. Its kind is 3 (add) when ascending and 4 (subtract) when descending.
- R9: `uop_last` is 1 on the final micro-op of an instruction only. The cycle after it is consumed, `uop_valid` is 0 and `in_ready` is 1.
- R10: An empty mask yields only the copy micro-op flagged last. With base update, a zero-offset add or subtract follows it and carries the last flag.
- R11: `in_ready` is 1 after reset and when idle, and 0 while a sequence is in progress. Instructions offered while busy are ignored.
- R12: While `uop_valid` is 1 and `uop_ready` is 0, all micro-op outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, instruction accepted when valid |
| in_list | input | 16 | Register mask |
| in_rn | input | 4 | Base register number |
| in_pre | input | 1 | Pre-increment: offset by one slot |
| in_up | input | 1 | Ascending addresses |
| in_user | input | 1 | Map transfer registers to user-bank aliases |
| in_wb | input | 1 | Update base register at the end |
| in_load | input | 1 | Load (1) or store (0) |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_kind | output | 3 | 0 copy, 1 load, 2 store, 3 add, 4 subtract |
| uop_reg | output | 6 | Destination or transferred register index |
| uop_base | output | 6 | Base register index |
| uop_ofs | output | 7 | Byte offset or immediate |
| uop_last | output | 1 | Final micro-op of the instruction |

## Verification
The bench tries empty, single-bit, top-bit-only, full and random masks under all 32 flag combinations. Empty masks separate the copy-only and copy-plus-update endings. Single-bit and full masks expose the off-by-one cases of the descending start offset with and without pre-increment. Random masks with ascending and descending direction tell apart scan order from offset direction. Random stalls on `uop_ready`, together with junk instructions offered during busy cycles, show that the outputs hold steady and that busy-time requests are dropped.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  typedef enum logic [2:0] {
    UOP_COPY  = 3'd0,
    UOP_LOAD  = 3'd1,
    UOP_STORE = 3'd2,
    UOP_ADDI  = 3'd3,
    UOP_SUBI  = 3'd4
  } uop_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BASE,
    ST_XFER,
    ST_WB
  } seq_state_e;

  typedef struct packed {
    logic pre;
    logic up;
    logic user;
    logic wb;
    logic load;
  } xfer_flags_t;

endpackage

// File: rtl/blkxfer_popcnt.sv
module blkxfer_popcnt #(
  parameter int LIST_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic [LIST_W-1:0] bits_i,
  output logic [CNT_W-1:0]  count_o
);

  logic [CNT_W-1:0] acc [LIST_W+1];

  assign acc[0] = '0;

  for (genvar g = 0; g < LIST_W; g++) begin : g_sum
    assign acc[g+1] = acc[g] + CNT_W'(bits_i[g]);
  end

  assign count_o = acc[LIST_W];

endmodule

// File: rtl/blkxfer_scan.sv
module blkxfer_scan #(
  parameter int LIST_W = 16,
  parameter int POS_W  = 4
) (
  input  logic [LIST_W-1:0] list_i,
  output logic [LIST_W-1:0] low_o,
  output logic [POS_W-1:0]  pos_o,
  output logic              more_o
);

  logic [LIST_W:0]  seen;
  logic [POS_W-1:0] pos_acc [LIST_W+1];

  assign seen[0]    = 1'b0;
  assign pos_acc[0] = '0;

  for (genvar g = 0; g < LIST_W; g++) begin : g_scan
    assign seen[g+1]    = seen[g] | list_i[g];
    assign low_o[g]     = list_i[g] & ~seen[g];
    assign pos_acc[g+1] = pos_acc[g] | (low_o[g] ? POS_W'(g) : '0);
  end

  assign pos_o  = pos_acc[LIST_W];
  assign more_o = |(list_i & ~low_o);

  always_comb begin
    // R3
    scan_onehot_chk: assert ($onehot0(low_o) && ((low_o != '0) == (list_i != '0)));
  end

endmodule

// File: rtl/blkxfer_ctrl.sv
module blkxfer_ctrl
  import blkxfer_pkg::*;
#(
  parameter int LIST_W   = 16,
  parameter int POS_W    = 4,
  parameter int CNT_W    = 5,
  parameter int IDX_W    = 6,
  parameter int OFS_W    = 7,
  parameter int TEMP_REG = 32,
  parameter int USER_OFS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LIST_W-1:0] in_list,
  input  logic [POS_W-1:0]  in_rn,
  input  xfer_flags_t       in_flags,
  input  logic [CNT_W-1:0]  in_count,
  output logic [LIST_W-1:0] work_o,
  input  logic [LIST_W-1:0] low_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              more_i,
  output logic              uop_valid,
  input  logic              uop_ready,
  output logic [2:0]        uop_kind,
  output logic [IDX_W-1:0]  uop_reg,
  output logic [IDX_W-1:0]  uop_base,
  output logic [OFS_W-1:0]  uop_ofs,
  output logic              uop_last
);

  localparam logic [OFS_W-1:0] STEP = OFS_W'(4);
  localparam int               SENT_W = CNT_W + 1;

  seq_state_e        state_q, state_d;
  logic [LIST_W-1:0] work_q, work_d;
  logic [OFS_W-1:0]  ofs_q, ofs_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [POS_W-1:0]  rn_q;
  xfer_flags_t       flags_q;
  logic [SENT_W-1:0] sent_q, sent_d;

  logic             accept, fire, ld_en, step_en, sent_en;
  logic [OFS_W-1:0] start_ofs, down_ofs;
  uop_kind_e        kind_c;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign fire     = uop_valid && uop_ready;
  assign work_o   = work_q;

  assign down_ofs  = (OFS_W'(in_count) << 2) - STEP;
  assign start_ofs = (in_flags.up ? '0 : down_ofs) + (in_flags.pre ? STEP : '0);

  assign ld_en   = accept;
  assign step_en = fire && (state_q == ST_XFER);
  assign sent_en = accept || fire;

  // next-state process
  always_comb begin
    state_d = state_q;
    work_d  = work_q;
    ofs_d   = ofs_q;
    sent_d  = sent_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_BASE;
          work_d  = in_list;
          ofs_d   = start_ofs;
          sent_d  = '0;
        end
      end
      ST_BASE: begin
        if (fire) begin
          sent_d = sent_q + SENT_W'(1);
          if (work_q != '0)    state_d = ST_XFER;
          else if (flags_q.wb) state_d = ST_WB;
          else                 state_d = ST_IDLE;
        end
      end
      ST_XFER: begin
        if (fire) begin
          sent_d = sent_q + SENT_W'(1);
          work_d = work_q & ~low_i;
          ofs_d  = flags_q.up ? ofs_q + STEP : ofs_q - STEP;
          if (more_i)          state_d = ST_XFER;
          else if (flags_q.wb) state_d = ST_WB;
          else                 state_d = ST_IDLE;
        end
      end
      ST_WB: begin
        if (fire) begin
          sent_d  = sent_q + SENT_W'(1);
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      work_q  <= '0;
      ofs_q   <= '0;
      cnt_q   <= '0;
      rn_q    <= '0;
      flags_q <= '0;
      sent_q  <= '0;
    end else begin
      state_q <= state_d;
      if (ld_en || step_en) begin
        work_q <= work_d;
        ofs_q  <= ofs_d;
      end
      if (ld_en) begin
        cnt_q   <= in_count;
        rn_q    <= in_rn;
        flags_q <= in_flags;
      end
      if (sent_en) sent_q <= sent_d;
    end
  end

  // micro-op output decode
  always_comb begin
    uop_valid = (state_q != ST_IDLE);
    kind_c    = UOP_COPY;
    uop_reg   = '0;
    uop_base  = '0;
    uop_ofs   = '0;
    uop_last  = 1'b0;
    unique case (state_q)
      ST_BASE: begin
        kind_c   = UOP_COPY;
        uop_reg  = IDX_W'(TEMP_REG);
        uop_base = IDX_W'(rn_q);
        uop_last = (work_q == '0) && !flags_q.wb;
      end
      ST_XFER: begin
        kind_c   = flags_q.load ? UOP_LOAD : UOP_STORE;
        uop_reg  = IDX_W'(pos_i) + (flags_q.user ? IDX_W'(USER_OFS) : '0);
        uop_base = IDX_W'(TEMP_REG);
        uop_ofs  = ofs_q;
        uop_last = !more_i && !flags_q.wb;
      end
      ST_WB: begin
        kind_c   = flags_q.up ? UOP_ADDI : UOP_SUBI;
        uop_reg  = IDX_W'(rn_q);
        uop_base = IDX_W'(rn_q);
        uop_ofs  = OFS_W'(cnt_q) << 2;
        uop_last = 1'b1;
      end
      default: ;
    endcase
    uop_kind = kind_c;
  end

  // R12
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !uop_ready |=> uop_valid && $stable(uop_kind) && $stable(uop_reg)
      && $stable(uop_base) && $stable(uop_ofs) && $stable(uop_last));

  // R2
  first_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> uop_valid && (uop_kind == 3'd0) && (uop_ofs == '0));

  // R9
  last_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && uop_last |=> !uop_valid && in_ready);

  // R9
  not_last_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !uop_last |=> uop_valid);

  // R5
  ofs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && more_i |=> (uop_ofs == ($past(flags_q.up) ? $past(uop_ofs) + STEP
                                                         : $past(uop_ofs) - STEP)));

  // R1
  uop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && uop_last |-> (sent_q + SENT_W'(1)) == (SENT_W'(cnt_q) + SENT_W'(flags_q.wb) + SENT_W'(1)));

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter  int LIST_W   = 16,
  parameter  int TEMP_REG = 32,
  parameter  int USER_OFS = 40,
  localparam int POS_W    = $clog2(LIST_W),
  localparam int CNT_W    = $clog2(LIST_W + 1),
  localparam int IDX_W    = $clog2(USER_OFS + LIST_W),
  localparam int OFS_W    = $clog2(4 * LIST_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LIST_W-1:0] in_list,
  input  logic [POS_W-1:0]  in_rn,
  input  logic              in_pre,
  input  logic              in_up,
  input  logic              in_user,
  input  logic              in_wb,
  input  logic              in_load,
  output logic              uop_valid,
  input  logic              uop_ready,
  output logic [2:0]        uop_kind,
  output logic [IDX_W-1:0]  uop_reg,
  output logic [IDX_W-1:0]  uop_base,
  output logic [OFS_W-1:0]  uop_ofs,
  output logic              uop_last
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  xfer_flags_t       flags;
  logic [CNT_W-1:0]  count;
  logic [LIST_W-1:0] work, low;
  logic [POS_W-1:0]  pos;
  logic              more;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign flags = '{pre: in_pre, up: in_up, user: in_user, wb: in_wb, load: in_load};

  blkxfer_popcnt #(.LIST_W(LIST_W), .CNT_W(CNT_W)) i_popcnt (
    .bits_i  (in_list),
    .count_o (count)
  );

  blkxfer_scan #(.LIST_W(LIST_W), .POS_W(POS_W)) i_scan (
    .list_i (work),
    .low_o  (low),
    .pos_o  (pos),
    .more_o (more)
  );

  blkxfer_ctrl #(
    .LIST_W(LIST_W), .POS_W(POS_W), .CNT_W(CNT_W), .IDX_W(IDX_W),
    .OFS_W(OFS_W), .TEMP_REG(TEMP_REG), .USER_OFS(USER_OFS)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_list   (in_list),
    .in_rn     (in_rn),
    .in_flags  (flags),
    .in_count  (count),
    .work_o    (work),
    .low_i     (low),
    .pos_i     (pos),
    .more_i    (more),
    .uop_valid (uop_valid),
    .uop_ready (uop_ready),
    .uop_kind  (uop_kind),
    .uop_reg   (uop_reg),
    .uop_base  (uop_base),
    .uop_ofs   (uop_ofs),
    .uop_last  (uop_last)
  );

endmodule

// File: tb/test_blkxfer_seq.sv
module test_blkxfer_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_list = '0;
  logic [3:0]  in_rn = '0;
  logic        in_pre = 1'b0, in_up = 1'b0, in_user = 1'b0, in_wb = 1'b0, in_load = 1'b0;
  logic        uop_valid;
  logic        uop_ready = 1'b0;
  logic [2:0]  uop_kind;
  logic [5:0]  uop_reg, uop_base;
  logic [6:0]  uop_ofs;
  logic        uop_last;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int e_kind [20];
  int e_reg  [20];
  int e_base [20];
  int e_ofs  [20];
  int e_last [20];
  int e_n;

  always #4 clk = ~clk;

  blkxfer_seq i_blkxfer_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_list(in_list), .in_rn(in_rn), .in_pre(in_pre), .in_up(in_up),
    .in_user(in_user), .in_wb(in_wb), .in_load(in_load),
    .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_kind(uop_kind),
    .uop_reg(uop_reg), .uop_base(uop_base), .uop_ofs(uop_ofs), .uop_last(uop_last)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model of the expected micro-op stream
  task automatic build_exp(input logic [15:0] l, input logic [3:0] rn,
                           input logic pre, input logic up, input logic user,
                           input logic wb, input logic ld);
    int n = 0;
    int a;
    int k;
    for (int r = 0; r < 16; r++) if (l[r]) n++;
    e_kind[0] = 0; e_reg[0] = 32; e_base[0] = rn; e_ofs[0] = 0;
    a = up ? 0 : 4 * n - 4;
    if (pre) a += 4;
    k = 1;
    for (int r = 0; r < 16; r++) begin
      if (l[r]) begin
        e_kind[k] = ld ? 1 : 2;
        e_reg[k]  = r + (user ? 40 : 0);
        e_base[k] = 32;
        e_ofs[k]  = a & 127;
        a = up ? a + 4 : a - 4;
        k++;
      end
    end
    if (wb) begin
      e_kind[k] = up ? 3 : 4;
      e_reg[k] = rn; e_base[k] = rn; e_ofs[k] = 4 * n;
      k++;
    end
    for (int i = 0; i < k; i++) e_last[i] = (i == k - 1) ? 1 : 0;
    e_n = k;
  endtask

  task automatic run_instr(input logic [15:0] l, input logic [3:0] rn,
                           input logic pre, input logic up, input logic user,
                           input logic wb, input logic ld);
    int    idx = 0;
    bit    stalled = 0;
    bit    rdy;
    bit    empty = (l == 16'h0);
    int    s_kind = 0, s_reg = 0, s_base = 0, s_ofs = 0, s_last = 0;
    int    guard = 0;
    string tk;
    build_exp(l, rn, pre, up, user, wb, ld);
    @(negedge clk);
    in_valid = 1'b1; in_list = l; in_rn = rn;
    in_pre = pre; in_up = up; in_user = user; in_wb = wb; in_load = ld;
    uop_ready = 1'b0;
    chk(in_ready == 1'b1, "R11", "in_ready when idle", int'(in_ready), 1);
    @(negedge clk);
    // junk instruction offered while busy: must be ignored
    in_list = 16'($urandom); in_rn = 4'($urandom);
    {in_pre, in_up, in_user, in_wb, in_load} = 5'($urandom);
    while (idx < e_n && guard < 400) begin
      guard++;
      rdy = ($urandom % 4) != 0;
      chk(in_ready == 1'b0, "R11", "in_ready while busy", int'(in_ready), 0);
      chk(uop_valid == 1'b1, "R1", "uop_valid mid-sequence", int'(uop_valid), 1);
      if (stalled) begin
        chk(uop_kind == s_kind && uop_reg == s_reg && uop_base == s_base &&
            uop_ofs == s_ofs && uop_last == s_last, "R12", "hold during stall",
            int'(uop_ofs), s_ofs);
      end
      if (rdy) begin
        if (idx == 0)              tk = empty ? "R10" : "R2";
        else if (wb && idx == e_n - 1) tk = empty ? "R10" : "R8";
        else                       tk = "R6";
        chk(uop_kind == e_kind[idx], tk, "kind", int'(uop_kind), e_kind[idx]);
        if (idx == 0 || (wb && idx == e_n - 1)) tk = empty ? "R10" : (idx == 0 ? "R2" : "R8");
        else                       tk = user ? "R7" : "R3";
        chk(uop_reg == e_reg[idx], tk, "reg", int'(uop_reg), e_reg[idx]);
        chk(uop_base == e_base[idx], tk, "base", int'(uop_base), e_base[idx]);
        if (idx == 0)              tk = "R2";
        else if (wb && idx == e_n - 1) tk = "R8";
        else if (idx == 1)         tk = "R4";
        else                       tk = "R5";
        chk(uop_ofs == e_ofs[idx], tk, "offset", int'(uop_ofs), e_ofs[idx]);
        chk(uop_last == e_last[idx], empty ? "R10" : "R9", "last", int'(uop_last), e_last[idx]);
        if (idx == e_n - 1) in_valid = 1'b0;
        idx++;
        stalled = 0;
      end else begin
        s_kind = uop_kind; s_reg = uop_reg; s_base = uop_base;
        s_ofs = uop_ofs; s_last = uop_last;
        stalled = 1;
      end
      uop_ready = rdy;
      @(negedge clk);
    end
    uop_ready = 1'b0;
    in_valid = 1'b0;
    chk(uop_valid == 1'b0, "R1", "uop_valid after expected count", int'(uop_valid), 0);
    chk(in_ready == 1'b1, "R9", "in_ready after last", int'(in_ready), 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R11", "in_ready after reset", int'(in_ready), 1);
    chk(uop_valid == 1'b0, "R11", "uop_valid after reset", int'(uop_valid), 0);

    // directed corners
    run_instr(16'h0000, 4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1); // R10 copy only
    run_instr(16'h0000, 4'd5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0); // R10 zero subtract
    run_instr(16'h0000, 4'd6, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0); // R10 zero add
    run_instr(16'hFFFF, 4'd13, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1); // full, up, pre
    run_instr(16'hFFFF, 4'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); // full, down, post
    run_instr(16'h8000, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1); // single top bit
    run_instr(16'h0001, 4'd15, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); // single low bit
    run_instr(16'h8001, 4'd7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);

    // every flag combination with random masks
    for (int f = 0; f < 32; f++) begin
      run_instr(16'($urandom), 4'($urandom), f[4], f[3], f[2], f[1], f[0]);
    end
    for (int t = 0; t < 40; t++) begin
      run_instr(16'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule